// File: doc/BRIEF.md
# Region-Tracked Fast Clear Buffer

This block is an on-chip word buffer that can be returned to all-zero quickly. Next to the storage it keeps a small bitmap with one mark per region of `REGION_WORDS` consecutive words. Any accepted write of a nonzero value sets the mark of the region it lands in. A write of zero leaves the marks as they are.

A clear command starts a sequencer that walks the bitmap from region 0 upward. It spends one cycle on each unmarked region. For each marked region it writes zero to every word of that region, one word per cycle, and then drops the mark. While the sequencer runs, `busy` is high, and all read, write and further clear requests are ignored. A one-cycle `clear_done` pulse marks the end of the clear. The cost of a clear therefore grows with the number of regions that were written since the last clear, not with the size of the buffer.

Reads are registered: the word appears on `rd_data` with `rd_valid` one cycle after the request. `REGION_WORDS` must be a power of two, at least 2, and the buffer must hold at least two regions. The last region may be partial when `DEPTH` is not a multiple of `REGION_WORDS`.

Top module: `regclr_buf`

## Requirements
- R1: After reset every word reads as zero, no region is marked, and `busy`, `clear_done` and `rd_valid` are low.
- R2: A read accepted at a clock edge drives `rd_valid` high and the word on `rd_data` after that edge. A read and a write to the same address at the same edge return the old word.
- R3: An accepted write with nonzero data to index k marks region floor(k/REGION_WORDS). A write of zero sets no mark.
- R4: After a clear, every word of every region that was marked reads as zero.
- R5: `busy` rises at the edge after an accepted `clear_req` and stays high for exactly the sum, over all regions, of the region's word count if it is marked, or 1 if it is not.
- R6: `clear_done` is high for exactly one cycle, in the first cycle after `busy` falls.
- R7: A clear leaves no region marked, so an immediate second clear lasts exactly as many cycles as there are regions.
- R8: While `busy` is high, writes change no word and set no mark, and reads are not accepted (`rd_valid` stays low).
- R9: `clear_req` while `busy` is high is ignored and does not lengthen or restart the clear.
- R10: A write to an address at or above `DEPTH` changes nothing and sets no mark. A read of such an address returns zero.
- R11: For a partial last region, a clear spends only as many cycles as that region has words.
- R12: A write and a `clear_req` at the same edge are both accepted, and the write's mark is included in the clear that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write word index |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word index |
| rd_data | output | DATA_W | Read data, registered |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a newly read word |
| clear_req | input | 1 | Start a clear of all marked regions |
| busy | output | 1 | A clear is running; requests are ignored |
| clear_done | output | 1 | One-cycle pulse at the end of a clear |

## Verification
A write is visible to a read issued one edge later, and read data is sampled at the falling edge after the edge that accepted the read. `busy` is sampled at every falling edge from the first edge after the clear request. The number of high samples must equal the cost the bench computes from its own model of the marks. `clear_done` must be high at the first low sample of `busy` and low at the next one. The marks are never read directly: whether a write set one is inferred from the length of the next clear, and the contents are checked by reading every address back after each clear.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_SCAN = 1'b1
    } seq_state_e;

endpackage

// File: rtl/rfc_word_store.sv
module rfc_word_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            rdata;
        logic                         rvalid;
    } store_t;

    store_t st_d, st_q;
    logic   w_in_range;
    logic   r_in_range;

    assign w_in_range = ({1'b0, waddr} < LIMIT);
    assign r_in_range = ({1'b0, raddr} < LIMIT);

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = re;
        if (re) begin
            if (r_in_range) begin
                st_d.rdata = st_q.mem[raddr];
            end else begin
                st_d.rdata = '0;
            end
        end
        if (we && w_in_range) begin
            st_d.mem[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;

endmodule

// File: rtl/rfc_region_map.sv
module rfc_region_map #(
    parameter int NREG  = 8,
    parameter int REG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_idx,
    output logic [NREG-1:0]  marks
);

    typedef struct packed {
        logic [NREG-1:0] bits;
    } map_t;

    map_t map_d, map_q;

    always_comb begin
        map_d = map_q;
        for (int i = 0; i < NREG; i++) begin
            if (set_en && (set_idx == REG_W'(i))) begin
                map_d.bits[i] = 1'b1;
            end
            if (clr_en && (clr_idx == REG_W'(i))) begin
                map_d.bits[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    assign marks = map_q.bits;

endmodule

// File: rtl/rfc_clear_seq.sv
module rfc_clear_seq
    import rfc_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int NREG   = 8,
    parameter int REG_W  = 3,
    parameter int OFF_W  = 3,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NREG-1:0]   marks,
    output logic              busy,
    output logic              done,
    output logic              zero_en,
    output logic [ADDR_W-1:0] zero_addr,
    output logic              mark_clr_en,
    output logic [REG_W-1:0]  mark_clr_idx
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [REG_W-1:0]  LAST_REG  = REG_W'(NREG - 1);
    localparam logic [OFF_W-1:0]  LAST_OFF  = '1;

    typedef struct packed {
        seq_state_e       state;
        logic [REG_W-1:0] reg_idx;
        logic [OFF_W-1:0] off;
        logic             done;
    } seq_t;

    seq_t sq_d, sq_q;

    logic scanning;
    logic cur_marked;
    logic last_word;
    logic region_end;

    always_comb begin
        scanning   = (sq_q.state == SEQ_SCAN);
        cur_marked = marks[sq_q.reg_idx];
        zero_addr  = {sq_q.reg_idx, sq_q.off};
        last_word  = (sq_q.off == LAST_OFF) || (zero_addr == LAST_ADDR);
        region_end = scanning && (!cur_marked || last_word);

        zero_en      = scanning && cur_marked;
        mark_clr_en  = scanning && cur_marked && last_word;
        mark_clr_idx = sq_q.reg_idx;

        sq_d      = sq_q;
        sq_d.done = 1'b0;
        unique case (sq_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    sq_d.state   = SEQ_SCAN;
                    sq_d.reg_idx = '0;
                    sq_d.off     = '0;
                end
            end
            SEQ_SCAN: begin
                if (region_end) begin
                    sq_d.off = '0;
                    if (sq_q.reg_idx == LAST_REG) begin
                        sq_d.state = SEQ_IDLE;
                        sq_d.done  = 1'b1;
                    end else begin
                        sq_d.reg_idx = sq_q.reg_idx + 1'b1;
                    end
                end else begin
                    sq_d.off = sq_q.off + 1'b1;
                end
            end
            default: sq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{state: SEQ_IDLE, reg_idx: '0, off: '0, done: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy = (sq_q.state == SEQ_SCAN);
    assign done = sq_q.done;

endmodule

// File: rtl/regclr_buf.sv
module regclr_buf #(
    parameter int DEPTH        = 64,
    parameter int DATA_W       = 16,
    parameter int REGION_WORDS = 8,
    parameter int NREG         = (DEPTH + REGION_WORDS - 1) / REGION_WORDS,
    parameter int OFF_W        = $clog2(REGION_WORDS),
    parameter int REG_W        = $clog2(NREG),
    parameter int ADDR_W       = REG_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              clear_req,
    output logic              busy,
    output logic              clear_done
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    logic              start;
    logic              user_we;
    logic              user_re;
    logic              mark_set;
    logic [NREG-1:0]   marks;
    logic              zero_en;
    logic [ADDR_W-1:0] zero_addr;
    logic              mark_clr_en;
    logic [REG_W-1:0]  mark_clr_idx;
    logic              store_we;
    logic [ADDR_W-1:0] store_waddr;
    logic [DATA_W-1:0] store_wdata;

    always_comb begin
        start    = clear_req && !busy;
        user_we  = wr_en && !busy;
        user_re  = rd_en && !busy;
        mark_set = user_we && (wr_data != '0) && ({1'b0, wr_addr} < LIMIT);

        store_we = user_we || zero_en;
        if (zero_en) begin
            store_waddr = zero_addr;
            store_wdata = '0;
        end else begin
            store_waddr = wr_addr;
            store_wdata = wr_data;
        end
    end

    rfc_word_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (store_we),
        .waddr  (store_waddr),
        .wdata  (store_wdata),
        .re     (user_re),
        .raddr  (rd_addr),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

    rfc_region_map #(
        .NREG  (NREG),
        .REG_W (REG_W)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (mark_set),
        .set_idx (wr_addr[ADDR_W-1:OFF_W]),
        .clr_en  (mark_clr_en),
        .clr_idx (mark_clr_idx),
        .marks   (marks)
    );

    rfc_clear_seq #(
        .DEPTH  (DEPTH),
        .NREG   (NREG),
        .REG_W  (REG_W),
        .OFF_W  (OFF_W),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .marks        (marks),
        .busy         (busy),
        .done         (clear_done),
        .zero_en      (zero_en),
        .zero_addr    (zero_addr),
        .mark_clr_en  (mark_clr_en),
        .mark_clr_idx (mark_clr_idx)
    );

endmodule

// File: rtl/regclr_buf_chk.sv
module regclr_buf_chk #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    parameter int OFF_W  = 3,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_valid,
    input logic              clear_req,
    input logic              busy,
    input logic              clear_done,
    input logic [NREG-1:0]   marks
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    // R6: the end-of-clear pulse lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_done |=> !clear_done);

    // R6: busy falling is accompanied by the pulse
    p_done_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> clear_done);

    // R5: a clear only begins after a request
    p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(clear_req));

    // R8: no read is accepted while busy
    p_no_read_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid);

    // R3: a nonzero write in range marks its region
    p_mark_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && (wr_data != '0) && ({1'b0, wr_addr} < LIMIT))
        |=> marks[$past(wr_addr[ADDR_W-1:OFF_W])]);

    // R7: nothing is marked when a clear finishes
    p_marks_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_done |-> (marks == '0));

endmodule

bind regclr_buf regclr_buf_chk #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .NREG   (NREG),
    .OFF_W  (OFF_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_valid   (rd_valid),
    .clear_req  (clear_req),
    .busy       (busy),
    .clear_done (clear_done),
    .marks      (marks)
);

// File: tb/regclr_buf_test.sv
`timescale 1ns/1ps
module regclr_buf_test;

    localparam int DEPTH = 22;
    localparam int RW    = 4;
    localparam int DW    = 8;
    localparam int NREG  = 6;
    localparam int AW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          clear_req = 1'b0;
    logic          busy;
    logic          clear_done;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] exp_mem [DEPTH];
    bit            exp_mark[NREG];

    always #10 clk = ~clk;

    regclr_buf #(.DEPTH(DEPTH), .DATA_W(DW), .REGION_WORDS(RW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .clear_req(clear_req),
        .busy(busy), .clear_done(clear_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int words_in(input int r);
        return (DEPTH - r * RW < RW) ? DEPTH - r * RW : RW;
    endfunction

    function automatic int clear_cost();
        int c = 0;
        for (int r = 0; r < NREG; r++) c += exp_mark[r] ? words_in(r) : 1;
        return c;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (a < DEPTH) begin
            exp_mem[a] = DW'(d);
            if (d != 0) exp_mark[a / RW] = 1'b1;
        end
    endtask

    task automatic rd_chk(input int a, input string req);
        int e;
        e = (a < DEPTH) ? int'(exp_mem[a]) : 0;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(posedge clk); #1;
        rd_en = 1'b0;
        @(negedge clk);
        check(rd_valid === 1'b1 && int'(rd_data) == e, req, int'(rd_data), e);
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < DEPTH; a++) rd_chk(a, req);
    endtask

    task automatic do_clear(input bit noise, input string req);
        int n = 0;
        int e;
        e = clear_cost();
        @(negedge clk);
        clear_req = 1'b1;
        @(posedge clk); #1;
        if (noise) begin
            wr_en = 1'b1; wr_addr = AW'(1); wr_data = 8'h55;
            rd_en = 1'b1; rd_addr = AW'(1);
        end else begin
            clear_req = 1'b0;
        end
        @(negedge clk);
        while (busy === 1'b1 && n < 2000) begin
            n++;
            if (clear_done !== 1'b0) check(1'b0, "R6", 1, 0);
            if (noise && rd_valid !== 1'b0) check(1'b0, "R8", 1, 0);
            @(negedge clk);
        end
        clear_req = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        check(n == e, req, n, e);
        check(clear_done === 1'b1, "R6", int'(clear_done), 1);
        @(negedge clk);
        check(clear_done === 1'b0, "R6", int'(clear_done), 0);
        for (int r = 0; r < NREG; r++) begin
            if (exp_mark[r]) begin
                for (int w = 0; w < words_in(r); w++) exp_mem[r * RW + w] = '0;
            end
            exp_mark[r] = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = '0;
        for (int r = 0; r < NREG; r++) exp_mark[r] = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        check(busy === 1'b0, "R1", int'(busy), 0);
        check(clear_done === 1'b0, "R1", int'(clear_done), 0);
        check(rd_valid === 1'b0, "R1", int'(rd_valid), 0);
        rst_n = 1'b1;
        read_all("R1");
        do_clear(1'b0, "R1");

        // R2: fill every word and read it back
        for (int a = 0; a < DEPTH; a++) wr(a, ((a * 7 + 3) & 8'hFF) | 1);
        read_all("R2");
        // R2: read and write at the same edge return the old word
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(5);
        wr_en = 1'b1; wr_addr = AW'(5); wr_data = 8'h99;
        @(posedge clk); #1;
        rd_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        check(int'(rd_data) == int'(exp_mem[5]), "R2", int'(rd_data), int'(exp_mem[5]));
        exp_mem[5] = 8'h99;
        rd_chk(5, "R2");

        // R4 and R11: everything marked, partial last region included
        do_clear(1'b0, "R11");
        read_all("R4");

        // R3: zero writes set no mark
        for (int a = 0; a < DEPTH; a++) wr(a, 0);
        do_clear(1'b0, "R3");

        // R10: out-of-range write is dropped
        wr(25, 9);
        rd_chk(25, "R10");
        do_clear(1'b0, "R10");

        // R12: write and clear at the same edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(9); wr_data = 8'h07;
        exp_mem[9] = 8'h07; exp_mark[2] = 1'b1;
        do_clear(1'b0, "R12");
        rd_chk(9, "R12");

        // R8 and R9: requests during a clear are ignored
        wr(13, 8'h21);
        do_clear(1'b1, "R9");
        rd_chk(1, "R8");
        do_clear(1'b0, "R8");
        do_clear(1'b0, "R7");

        // R5: sweep all region subsets
        for (int p = 0; p < (1 << NREG); p++) begin
            for (int r = 0; r < NREG; r++) begin
                if (p[r]) wr(r * RW + (p % words_in(r)), p + 1);
                else      wr(r * RW, 0);
            end
            read_all("R2");
            do_clear(1'b0, p[NREG-1] ? "R11" : "R5");
            read_all("R4");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule